// File: doc/BRIEF.md
# Instruction-Boundary Run Control

This block decides, at every instruction boundary, whether a processor core may start its next instruction. The core presents a boundary-valid flag together with the address of the instruction it is about to start. It then waits for as long as the block drives the park output high. A retire strobe tells the block when a launched instruction has finished.

Software steers the block through one control register write port and one breakpoint-address write port. Three mechanisms can park the core: a stored halt request, a single-step pulse that lets exactly one instruction through before the core parks again, and one address breakpoint. The breakpoint comparator compares the boundary address against a programmed value. A hit becomes a sticky stop that stays in force until software clears it. The breakpoint can be programmed while the core is still held in reset, so the core stops the first time it reaches that address. A read port returns the stored bits and a halted status. That status reports the core as halted only when it is actually sitting idle at a boundary.

Top module: `rc_runctl`

## Requirements
- R1: After reset, park is 0, halted is 0 and the control read value is 0.
- R2: Control bit 0 (halt request) is stored and reads back at bit 0. While it is 1, the core is parked at its next boundary and launches no further instruction. The boundary address it parks on is the one following the last retired instruction.
- R3: Halted (the output, and read bit 8) becomes 1 only after the core has been waiting at a boundary with park high. It stays 0 while a requested halt waits for an in-flight instruction to retire. It falls back to 0 within two cycles once the parking cause is removed.
- R4: Writing control bit 1 (step) while halted with halt request set lets exactly one instruction launch and retire, after which the core parks at the following address. Bits 1 and 3 always read 0.
- R5: A step write arriving while halted is 0 is ignored. It does not let an extra instruction run after a later halt.
- R6: With control bit 2 (breakpoint enable) set, a boundary whose address equals the breakpoint register parks the core in the same cycle, so the instruction at that address does not retire.
- R7: A breakpoint hit is sticky: the core stays parked after the halt request is cleared, until control bit 3 (breakpoint clear) is written. After the clear, the instruction at the breakpoint address runs without hitting again.
- R8: The breakpoint can be armed while the core is held in reset, and the core then stops the first time it reaches the address. With bit 2 clear, the same address causes no stop.
- R9: A step written while parked by a breakpoint hit (halt request 0) executes the instruction at the breakpoint address and parks at the next boundary, with the hit still in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control write data: bit 0 halt, bit 1 step, bit 2 breakpoint enable, bit 3 breakpoint clear |
| bpa_wr | input | 1 | Breakpoint address write strobe |
| bpa_wdata | input | PC_W | Breakpoint address write data |
| bnd_valid | input | 1 | Core is at an instruction boundary, waiting to start |
| bnd_pc | input | PC_W | Address of the instruction about to start |
| retire | input | 1 | One-cycle strobe: a launched instruction finished |
| park | output | 1 | Core must not start the instruction at the boundary |
| halted | output | 1 | Core is parked and idle at a boundary |
| ctl_rdata | output | CTL_W | Read value: bit 0 halt, bit 2 breakpoint enable, bit 8 halted |

## Verification
The assertions take for granted that the core, while parked, keeps presenting the same boundary address until it either launches or is reset. They also assume it raises retire only for an instruction it launched after seeing park low. The bench core model follows that contract: it holds its boundary address while parked, and it resets by dropping boundary-valid before changing the address. It draws one retire per launch after a latency that the bench sweeps from zero to ten cycles. Breakpoints and all core resets are applied only while the model is held off the boundary or is freely running, so no assumption is broken by the stimulus itself.

// File: rtl/rc_pkg.sv
package rc_pkg;

    // Control register bit positions (software-visible encoding)
    localparam int unsigned CB_HALT   = 0;
    localparam int unsigned CB_STEP   = 1;
    localparam int unsigned CB_BPEN   = 2;
    localparam int unsigned CB_BPCLR  = 3;
    localparam int unsigned CB_HALTED = 8;

    // Single-step window
    typedef enum logic [1:0] {
        STEP_IDLE   = 2'd0,  // no step in progress
        STEP_OPEN   = 2'd1,  // one launch is permitted
        STEP_FLIGHT = 2'd2   // stepped instruction launched, waiting for retire
    } step_e;

endpackage

// File: rtl/rc_ctlreg.sv
module rc_ctlreg #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned CTL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             bpa_wr,
    input  logic [PC_W-1:0]  bpa_wdata,
    output logic             halt_req,
    output logic             bp_en,
    output logic [PC_W-1:0]  bp_addr,
    output logic             step_pulse,
    output logic             clr_pulse
);
    import rc_pkg::*;

    typedef struct packed {
        logic            halt_req;
        logic            bp_en;
        logic [PC_W-1:0] bp_addr;
    } creg_t;

    creg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl_wr) begin
            r_d.halt_req = ctl_wdata[CB_HALT];
            r_d.bp_en    = ctl_wdata[CB_BPEN];
        end
        if (bpa_wr) begin
            r_d.bp_addr = bpa_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign halt_req   = r_q.halt_req;
    assign bp_en      = r_q.bp_en;
    assign bp_addr    = r_q.bp_addr;
    assign step_pulse = ctl_wr & ctl_wdata[CB_STEP];
    assign clr_pulse  = ctl_wr & ctl_wdata[CB_BPCLR];

    // R2: a control write is reflected in the stored halt bit next cycle
    assert_halt_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (halt_req == $past(ctl_wdata[CB_HALT])));

endmodule

// File: rtl/rc_bpunit.sv
module rc_bpunit #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned CMP_CHUNK = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bp_en,
    input  logic [PC_W-1:0] bp_addr,
    input  logic            bnd_valid,
    input  logic [PC_W-1:0] bnd_pc,
    input  logic            retire,
    input  logic            clr_pulse,
    input  logic            step_open,
    output logic            trip,
    output logic            hit,
    output logic            skip
);
    localparam int unsigned NCHUNK = (PC_W + CMP_CHUNK - 1) / CMP_CHUNK;
    localparam int unsigned PAD_W  = NCHUNK * CMP_CHUNK;

    typedef struct packed {
        logic hit;   // sticky breakpoint stop
        logic skip;  // resume past the breakpoint address once
    } bps_t;

    bps_t s_d, s_q;

    logic [PAD_W-1:0]  pc_ext, bp_ext;
    logic [NCHUNK-1:0] chunk_eq;
    logic              addr_eq;

    always_comb begin
        pc_ext = '0;
        bp_ext = '0;
        pc_ext[PC_W-1:0] = bnd_pc;
        bp_ext[PC_W-1:0] = bp_addr;
    end

    // Split compare: narrow equality slices, then one AND reduction
    for (genvar g = 0; g < NCHUNK; g++) begin : g_cmp
        assign chunk_eq[g] = (pc_ext[g*CMP_CHUNK +: CMP_CHUNK] == bp_ext[g*CMP_CHUNK +: CMP_CHUNK]);
    end

    assign addr_eq = &chunk_eq;
    assign trip    = bp_en & bnd_valid & addr_eq & ~s_q.skip & ~step_open;

    always_comb begin
        s_d = s_q;
        if (clr_pulse) begin
            s_d.hit = 1'b0;
        end else if (trip) begin
            s_d.hit = 1'b1;
        end
        if (clr_pulse && s_q.hit) begin
            s_d.skip = 1'b1;
        end else if (retire) begin
            s_d.skip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit  = s_q.hit;
    assign skip = s_q.skip;

    // R7: a hit survives every cycle without a clear
    assert_hit_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr_pulse) |=> hit);

    // R7: a clear always drops the hit
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !hit);

endmodule

// File: rtl/rc_stepfsm.sv
module rc_stepfsm (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_pulse,
    input  logic          launch,
    input  logic          retire,
    input  logic          bnd_valid,
    input  logic          park,
    output rc_pkg::step_e state,
    output logic          halted
);
    import rc_pkg::*;

    typedef struct packed {
        step_e st;
        logic  halted;
    } sfsm_t;

    sfsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            STEP_IDLE:   if (step_pulse && f_q.halted) f_d.st = STEP_OPEN;
            STEP_OPEN:   if (launch)                   f_d.st = STEP_FLIGHT;
            STEP_FLIGHT: if (retire)                   f_d.st = STEP_IDLE;
            default:                                   f_d.st = STEP_IDLE;
        endcase
        f_d.halted = bnd_valid & park;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '{st: STEP_IDLE, halted: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign state  = f_q.st;
    assign halted = f_q.halted;

    // R5: a step arriving while not halted leaves the window closed
    assert_step_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STEP_IDLE && step_pulse && !halted) |=> (state == STEP_IDLE));

    // R4: an open window closes on the first launch and waits for its retire
    assert_one_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STEP_OPEN && launch) |=> (state == STEP_FLIGHT));

endmodule

// File: rtl/rc_runctl.sv
module rc_runctl #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned CTL_W     = 16,
    parameter int unsigned CMP_CHUNK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             bpa_wr,
    input  logic [PC_W-1:0]  bpa_wdata,
    input  logic             bnd_valid,
    input  logic [PC_W-1:0]  bnd_pc,
    input  logic             retire,
    output logic             park,
    output logic             halted,
    output logic [CTL_W-1:0] ctl_rdata
);
    import rc_pkg::*;

    logic            halt_req, bp_en, step_pulse, clr_pulse;
    logic [PC_W-1:0] bp_addr;
    logic            trip, hit, skip, launch, step_open;
    step_e           st;

    rc_ctlreg #(.PC_W(PC_W), .CTL_W(CTL_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .bpa_wr     (bpa_wr),
        .bpa_wdata  (bpa_wdata),
        .halt_req   (halt_req),
        .bp_en      (bp_en),
        .bp_addr    (bp_addr),
        .step_pulse (step_pulse),
        .clr_pulse  (clr_pulse)
    );

    assign step_open = (st == STEP_OPEN);

    rc_bpunit #(.PC_W(PC_W), .CMP_CHUNK(CMP_CHUNK)) u_bp (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_en     (bp_en),
        .bp_addr   (bp_addr),
        .bnd_valid (bnd_valid),
        .bnd_pc    (bnd_pc),
        .retire    (retire),
        .clr_pulse (clr_pulse),
        .step_open (step_open),
        .trip      (trip),
        .hit       (hit),
        .skip      (skip)
    );

    always_comb begin
        park = 1'b0;
        unique case (st)
            STEP_OPEN:   park = 1'b0;
            STEP_FLIGHT: park = 1'b1;
            default:     park = halt_req | hit | trip;
        endcase
    end

    assign launch = bnd_valid & ~park;

    rc_stepfsm u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_pulse (step_pulse),
        .launch     (launch),
        .retire     (retire),
        .bnd_valid  (bnd_valid),
        .park       (park),
        .state      (st),
        .halted     (halted)
    );

    always_comb begin
        ctl_rdata            = '0;
        ctl_rdata[CB_HALT]   = halt_req;
        ctl_rdata[CB_BPEN]   = bp_en;
        ctl_rdata[CB_HALTED] = halted;
    end

    // R2: with a halt stored, only an open step window lets the core launch
    assert_launch_allowed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!halt_req || st == STEP_OPEN));

    // R2 (input contract): a parked core keeps its boundary address
    assert_parked_pc_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bnd_valid && park) && bnd_valid) |-> $stable(bnd_pc));

    // R3: halted only follows a cycle spent parked at a boundary
    assert_halted_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> $past(bnd_valid && park));

    // R6: an armed address match outside a step or resume never launches
    assert_match_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && bp_en && bnd_pc == bp_addr && st == STEP_IDLE && !skip) |-> park);

endmodule

// File: tb/rc_runctl_test.sv
module rc_runctl_test;
    localparam int unsigned PC_W = 32;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        ctl_wr;
    logic [15:0] ctl_wdata;
    logic        bpa_wr;
    logic [31:0] bpa_wdata;
    logic        bnd_valid;
    logic [31:0] bnd_pc;
    logic        retire;
    logic        park;
    logic        halted;
    logic [15:0] ctl_rdata;

    logic        core_hold;
    logic        busy;
    int          lat;
    int          cnt;
    int          retired_n;
    int          n_run;
    int          n_fail;

    rc_runctl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .bpa_wr    (bpa_wr),
        .bpa_wdata (bpa_wdata),
        .bnd_valid (bnd_valid),
        .bnd_pc    (bnd_pc),
        .retire    (retire),
        .park      (park),
        .halted    (halted),
        .ctl_rdata (ctl_rdata)
    );

    // Core model: sequential instructions 4 bytes apart, fixed latency
    always @(posedge clk) begin
        if (core_hold) begin
            bnd_valid <= 1'b0;
            bnd_pc    <= BASE;
            busy      <= 1'b0;
            cnt       <= 0;
            retire    <= 1'b0;
            retired_n <= 0;
        end else begin
            retire <= 1'b0;
            if (!busy && !bnd_valid) begin
                bnd_valid <= 1'b1;
            end else if (bnd_valid && !park) begin
                bnd_valid <= 1'b0;
                busy      <= 1'b1;
                cnt       <= lat;
            end else if (busy) begin
                if (cnt == 0) begin
                    retire    <= 1'b1;
                    busy      <= 1'b0;
                    bnd_pc    <= bnd_pc + 32'd4;
                    retired_n <= retired_n + 1;
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(input logic [15:0] v);
        @(negedge clk);
        ctl_wdata = v;
        ctl_wr    = 1'b1;
        @(negedge clk);
        ctl_wr    = 1'b0;
        ctl_wdata = '0;
    endtask

    task automatic set_bp(input logic [31:0] a);
        @(negedge clk);
        bpa_wdata = a;
        bpa_wr    = 1'b1;
        @(negedge clk);
        bpa_wr    = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_halt(input int maxc, output bit got);
        got = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (halted) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (run control sequence hung) actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit got;
        int n0;
        n_run = 0; n_fail = 0;
        rst_n = 1'b0; core_hold = 1'b1; lat = 1;
        ctl_wr = 1'b0; ctl_wdata = '0; bpa_wr = 1'b0; bpa_wdata = '0;
        tick(4);

        // R1: reset state
        check("R1 park", {31'd0, park}, 32'd0);
        check("R1 halted", {31'd0, halted}, 32'd0);
        check("R1 rdata", {16'd0, ctl_rdata}, 32'd0);
        rst_n = 1'b1;
        tick(2);

        // R6/R7/R8: breakpoint sweep over address and latency
        for (int l = 0; l < 3; l++) begin
            for (int k = 0; k < 6; k++) begin
                core_hold = 1'b1;
                lat = l;
                ctl(16'h0008);
                set_bp(BASE + 32'(4 * k));
                ctl(16'h0004);
                tick(2);
                check("R8 not halted while core in reset", {31'd0, halted}, 32'd0);
                core_hold = 1'b0;
                wait_halt(300, got);
                check("R8 stops at armed address", {31'd0, got}, 32'd1);
                check("R6 breakpoint instruction not retired", 32'(retired_n), 32'(k));
                check("R6 parked address", bnd_pc, BASE + 32'(4 * k));
                check("R6 park held", {31'd0, park}, 32'd1);
                ctl(16'h0004);
                tick(20);
                check("R7 hit sticky without halt request", 32'(retired_n), 32'(k));
                check("R7 halted while sticky", {31'd0, halted}, 32'd1);
                ctl(16'h000C);
                tick(40);
                check("R7 released after clear", {31'd0, halted}, 32'd0);
                check("R7 runs past breakpoint", {31'd0, retired_n > k}, 32'd1);
            end
        end

        // R8: disabled breakpoint does not stop
        core_hold = 1'b1; lat = 1;
        ctl(16'h0008);
        set_bp(BASE + 32'd8);
        ctl(16'h0000);
        core_hold = 1'b0;
        tick(60);
        check("R8 disabled no stop", {31'd0, halted}, 32'd0);
        check("R8 disabled runs on", {31'd0, retired_n > 2}, 32'd1);

        // R2/R3: halt requested during a long in-flight instruction
        lat = 10;
        for (int i = 0; i < 100 && bnd_valid; i++) @(negedge clk);
        ctl(16'h0001);
        tick(1);
        check("R3 not halted while in flight", {31'd0, halted}, 32'd0);
        check("R3 rdata while in flight", {16'd0, ctl_rdata}, 32'h0001);
        wait_halt(100, got);
        check("R3 halted after retire", {31'd0, got}, 32'd1);
        n0 = retired_n;
        check("R2 parked address", bnd_pc, BASE + 32'(4 * n0));
        tick(30);
        check("R2 no launch while halted", 32'(retired_n), 32'(n0));
        check("R3 rdata halted", {16'd0, ctl_rdata}, 32'h0101);

        // R4: single steps with varying latency
        for (int m = 0; m < 4; m++) begin
            lat = m;
            ctl(16'h0003);
            tick(1);
            wait_halt(100, got);
            check("R4 step parks again", {31'd0, got}, 32'd1);
            check("R4 exactly one retire", 32'(retired_n), 32'(n0 + m + 1));
            check("R4 next address", bnd_pc, BASE + 32'(4 * (n0 + m + 1)));
            check("R4 pulse bits read 0", {16'd0, ctl_rdata}, 32'h0101);
        end

        // R5: step while running is ignored
        lat = 1;
        ctl(16'h0000);
        tick(5);
        ctl(16'h0002);
        check("R5 rdata after ignored step", {16'd0, ctl_rdata}, 32'd0);
        tick(10);
        ctl(16'h0001);
        wait_halt(100, got);
        n0 = retired_n;
        tick(30);
        check("R5 no stale step", 32'(retired_n), 32'(n0));
        check("R5 still halted", {31'd0, halted}, 32'd1);

        // R9: step from a breakpoint hit with halt request clear
        ctl(16'h0008);
        core_hold = 1'b1;
        set_bp(BASE + 32'd12);
        ctl(16'h0004);
        core_hold = 1'b0;
        wait_halt(200, got);
        check("R9 breakpoint reached", 32'(retired_n), 32'd3);
        ctl(16'h0006);
        tick(1);
        wait_halt(100, got);
        check("R9 step executes breakpoint instruction", 32'(retired_n), 32'd4);
        check("R9 parks at next", bnd_pc, BASE + 32'd16);
        check("R9 hit still holds", {16'd0, ctl_rdata}, 32'h0104);

        // R3: release clears halted quickly
        ctl(16'h000C);
        tick(1);
        check("R3 halted falls on release", {31'd0, halted}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule